// File: doc/BRIEF.md
# Background Fetch Sequencer for a Multiplexed Video Memory Bus

This block drives a 14-bit video memory bus. The low 8 bits of the bus carry the address in one dot and the data in the next. The sequencer receives the current dot and line counts, a rendering enable, the scroll address register and the background pattern table select. From these it runs the background tile fetches of a scanline.

Each fetch takes two dots. In the first dot the block puts the address on the bus and raises ALE. In the second dot it pulls the active-low read strobe and samples the returned byte. After each useful fetch the captured byte leaves the block on a one-cycle strobe, tagged with its fetch kind. The block also pulses the increment and reload commands that the scroll logic uses. It does no scroll arithmetic itself.

A separate host port runs one slow data-port access at a time. The access has a wait dot, an address dot with ALE high, a hold dot with ALE low, and a transfer dot.

The request side uses valid/ready. A request is accepted in a cycle where `host_req_valid` and `host_req_ready` are both high. The request fields must stay stable while valid is high and ready is low. The captured fetch bytes and the host read response are valid-only pulses with no ready input: the bus is locked to the dot counter and cannot stall, so the consumer must take each pulse in the cycle it appears.

Top module: `bgf_sequencer`

## Requirements
- R1: During and immediately after reset, `ale` is low, `rd_n` and `wr_n` are high, `fb_valid` and `host_rsp_valid` are low, and `host_req_ready` is high when rendering is off.
- R2: On a render-active line, a dot in 1..256 or 321..340 is part of a fetch. An odd dot is an address dot: `ale` is high, `ad_oe` is high, and the address is on `{pa_hi, ad_out}`. The following even dot is a data dot: `rd_n` is low, `ad_oe` is low, and `pa_hi` keeps the address. For dots up to 336 the fetch kind is ((dot-1)>>1) mod 4, with the codes 0 name, 1 attribute, 2 low pattern plane, 3 high pattern plane.
- R3: The fetch addresses are formed from the scroll address v (15 bits) and the pattern select p as follows. Name: {2'b10, v[11:0]}. Attribute: {2'b10, v[11:10], 4'b1111, v[9:7], v[4:2]}. Pattern: {1'b0, p, tile, plane, v[14:12]}, where tile is the name byte fetched earlier in the same group and plane is 0 for low and 1 for high.
- R4: On a render-active line, dot 0 raises `ale` with the name address and asserts no read. Dots 257..320 drive no ALE and no read.
- R5: Dots 337..340 perform two name fetches whose data produces no `fb_valid` strobe.
- R6: In the cycle after each data dot of dots 1..336, `fb_valid` is high for one cycle. `fb_kind` carries the fetch kind code and `fb_data` carries the byte that was on `ad_in` during the data dot.
- R7: On a render-active line, `scroll_hinc` is high at dots 8, 16, …, 256, 328 and 336 and at no other dot.
- R8: On a render-active line, `scroll_vinc` is high at dot 256 only, and `scroll_hreload` is high at dot 257 only.
- R9: A line is render-active only when `render_en` is high and the line is 0..239 or 261. On any other line there is no ALE, no read, no `fb_valid` and no scroll strobe, unless a host access is running.
- R10: `host_req_ready` is high only when no host access is running and the line is not render-active. After acceptance the access takes four dots in this order: wait (bus idle), address (`ale` high, address driven), hold (`ale` low, address still driven), transfer.
- R11: In the transfer dot of a read, `rd_n` is low, and in the next cycle `host_rsp_valid` pulses with the byte sampled from `ad_in`. In the transfer dot of a write, `wr_n` is low and `ad_out` carries the write byte with `ad_oe` high.
- R12: `rd_n` and `wr_n` are never low together, and neither is low while `ale` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dot | input | 9 | Current dot within the line (0..340) |
| line | input | 9 | Current line (0..261) |
| render_en | input | 1 | Background rendering enable |
| scroll_v | input | 15 | Current scroll address register |
| pat_sel | input | 1 | Background pattern table select |
| host_req_valid | input | 1 | Host access request valid |
| host_req_ready | output | 1 | Host request accepted this cycle when valid |
| host_req_we | input | 1 | 1 = write, 0 = read |
| host_req_addr | input | 14 | Host access address |
| host_req_wdata | input | 8 | Host write byte |
| host_rsp_valid | output | 1 | One-cycle read response pulse |
| host_rsp_data | output | 8 | Read response byte |
| pa_hi | output | 6 | Upper address bits of the bus |
| ad_out | output | 8 | Low bus bits driven out (address or write data) |
| ad_oe | output | 1 | Drive enable for the low bus bits |
| ad_in | input | 8 | Low bus bits read back |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| fb_valid | output | 1 | Captured fetch byte strobe |
| fb_kind | output | 2 | Kind of the captured fetch |
| fb_data | output | 8 | Captured fetch byte |
| scroll_hinc | output | 1 | Horizontal scroll increment command |
| scroll_vinc | output | 1 | Vertical scroll increment command |
| scroll_hreload | output | 1 | Horizontal scroll reload command |

## Verification
The bus pins and the scroll strobes are decoded from the presented dot and line in the same cycle. The bench drives each dot on the falling edge and samples a little later, before the next rising edge. `fb_valid` and the tile byte are registered, so each expected strobe is carried forward one dot and compared on the next dot of the sweep. The host access runs across five cycles after acceptance: wait, address, hold and transfer, then the response pulse. The bench follows that sequence one falling edge at a time. The expected values come from the dot arithmetic and from a bench memory whose byte is a fixed function of the latched address.

// File: rtl/bgf_pkg.sv
package bgf_pkg;
  typedef enum logic [1:0] {
    FK_NAME = 2'd0,
    FK_ATTR = 2'd1,
    FK_PLO  = 2'd2,
    FK_PHI  = 2'd3
  } fetch_kind_e;

  typedef struct packed {
    logic        adr;       // address dot of a fetch
    logic        dat;       // data dot of a fetch
    logic        dummy;     // fetch whose data is discarded
    logic        idle_ale;  // lone ALE pulse at the first dot
    fetch_kind_e kind;
  } slot_t;

  typedef enum logic [2:0] {
    HP_IDLE,
    HP_WAIT,
    HP_ADDR,
    HP_HOLD,
    HP_XFER
  } host_state_e;
endpackage

// File: rtl/bgf_slot_decode.sv
module bgf_slot_decode
  import bgf_pkg::*;
#(
  parameter int DOT_W      = 9,
  parameter int TILE_END   = 256,
  parameter int PRE_FIRST  = 321,
  parameter int PRE_LAST   = 336,
  parameter int DUMMY_LAST = 340
) (
  input  logic [DOT_W-1:0] dot,
  output slot_t            slot,
  output logic             hinc,
  output logic             vinc,
  output logic             hreload
);
  localparam logic [DOT_W-1:0] L_ONE  = DOT_W'(1);
  localparam logic [DOT_W-1:0] L_TEND = DOT_W'(TILE_END);
  localparam logic [DOT_W-1:0] L_REL  = DOT_W'(TILE_END + 1);
  localparam logic [DOT_W-1:0] L_PF   = DOT_W'(PRE_FIRST);
  localparam logic [DOT_W-1:0] L_PL   = DOT_W'(PRE_LAST);
  localparam logic [DOT_W-1:0] L_DF   = DOT_W'(PRE_LAST + 1);
  localparam logic [DOT_W-1:0] L_DL   = DOT_W'(DUMMY_LAST);

  logic [DOT_W-1:0] dm1;
  logic             in_main;
  logic             in_dummy;

  always_comb begin
    dm1      = dot - L_ONE;
    in_main  = (dot >= L_ONE && dot <= L_TEND) || (dot >= L_PF && dot <= L_PL);
    in_dummy = (dot >= L_DF && dot <= L_DL);

    slot.adr      = (in_main || in_dummy) && !dm1[0];
    slot.dat      = (in_main || in_dummy) &&  dm1[0];
    slot.dummy    = in_dummy;
    slot.idle_ale = (dot == '0);
    slot.kind     = in_main ? fetch_kind_e'(dm1[2:1]) : FK_NAME;

    hinc    = in_main && (dm1[2:0] == 3'd7);
    vinc    = (dot == L_TEND);
    hreload = (dot == L_REL);
  end
endmodule

// File: rtl/bgf_addr_gen.sv
module bgf_addr_gen
  import bgf_pkg::*;
#(
  parameter int AW = 14,
  parameter int DW = 8,
  parameter int VW = 15
) (
  input  fetch_kind_e     kind,
  input  logic [VW-1:0]   v,
  input  logic [DW-1:0]   tile,
  input  logic            pat_sel,
  output logic [AW-1:0]   addr
);
  logic [AW-1:0] name_a;
  logic [AW-1:0] attr_a;
  logic [AW-1:0] pat_a [2];

  assign name_a = {2'b10, v[11:0]};
  assign attr_a = {2'b10, v[11:10], 4'b1111, v[9:7], v[4:2]};

  // one address per pattern plane; the plane index sits just above fine-y
  for (genvar pl = 0; pl < 2; pl++) begin : g_plane
    assign pat_a[pl] = {1'b0, pat_sel, tile, 1'(pl), v[14:12]};
  end

  always_comb begin
    unique case (kind)
      FK_NAME: addr = name_a;
      FK_ATTR: addr = attr_a;
      FK_PLO:  addr = pat_a[0];
      default: addr = pat_a[1];
    endcase
  end
endmodule

// File: rtl/bgf_host_port.sv
module bgf_host_port
  import bgf_pkg::*;
#(
  parameter int AW = 14,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          allow,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] ad_in,
  output logic          busy,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          drive_lo,
  output logic [AW-1:0] cur_addr,
  output logic [DW-1:0] lo_out,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  host_state_e   st;
  logic          we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q;
  logic          accept;

  assign req_ready = (st == HP_IDLE) && allow;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= HP_IDLE;
      we_q      <= 1'b0;
      addr_q    <= '0;
      wd_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= (st == HP_XFER) && !we_q;
      if ((st == HP_XFER) && !we_q) rsp_data <= ad_in;
      unique case (st)
        HP_IDLE: if (accept) begin
          st     <= HP_WAIT;
          we_q   <= req_we;
          addr_q <= req_addr;
          wd_q   <= req_wdata;
        end
        HP_WAIT: st <= HP_ADDR;
        HP_ADDR: st <= HP_HOLD;
        HP_HOLD: st <= HP_XFER;
        default: st <= HP_IDLE;
      endcase
    end
  end

  always_comb begin
    busy     = (st != HP_IDLE);
    ale      = (st == HP_ADDR);
    rd_n     = !((st == HP_XFER) && !we_q);
    wr_n     = !((st == HP_XFER) &&  we_q);
    drive_lo = (st == HP_ADDR) || (st == HP_HOLD) || ((st == HP_XFER) && we_q);
    cur_addr = addr_q;
    lo_out   = (st == HP_XFER) ? wd_q : addr_q[DW-1:0];
  end
endmodule

// File: rtl/bgf_sequencer.sv
module bgf_sequencer
  import bgf_pkg::*;
#(
  parameter int DOT_W     = 9,
  parameter int LINE_W    = 9,
  parameter int AW        = 14,
  parameter int DW        = 8,
  parameter int VW        = 15,
  parameter int VIS_LINES = 240,
  parameter int PRE_LINE  = 261
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DOT_W-1:0]  dot,
  input  logic [LINE_W-1:0] line,
  input  logic              render_en,
  input  logic [VW-1:0]     scroll_v,
  input  logic              pat_sel,
  input  logic              host_req_valid,
  output logic              host_req_ready,
  input  logic              host_req_we,
  input  logic [AW-1:0]     host_req_addr,
  input  logic [DW-1:0]     host_req_wdata,
  output logic              host_rsp_valid,
  output logic [DW-1:0]     host_rsp_data,
  output logic [AW-DW-1:0]  pa_hi,
  output logic [DW-1:0]     ad_out,
  output logic              ad_oe,
  input  logic [DW-1:0]     ad_in,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              fb_valid,
  output logic [1:0]        fb_kind,
  output logic [DW-1:0]     fb_data,
  output logic              scroll_hinc,
  output logic              scroll_vinc,
  output logic              scroll_hreload
);
  localparam logic [LINE_W-1:0] L_VIS = LINE_W'(VIS_LINES);
  localparam logic [LINE_W-1:0] L_PRE = LINE_W'(PRE_LINE);

  slot_t         slot;
  logic          s_hinc, s_vinc, s_hrel;
  logic          render_act;
  logic          fetch_drv;
  logic [DW-1:0] tile_q;
  logic [AW-1:0] f_addr;

  logic          host_busy;
  logic          h_ale, h_rd_n, h_wr_n, h_drive;
  logic [AW-1:0] h_addr;
  logic [DW-1:0] h_lo;

  assign render_act = render_en && ((line < L_VIS) || (line == L_PRE));
  assign fetch_drv  = render_act && !host_busy;

  bgf_slot_decode #(.DOT_W(DOT_W)) u_slot (
    .dot(dot), .slot(slot), .hinc(s_hinc), .vinc(s_vinc), .hreload(s_hrel)
  );

  bgf_addr_gen #(.AW(AW), .DW(DW), .VW(VW)) u_addr (
    .kind(slot.kind), .v(scroll_v), .tile(tile_q), .pat_sel(pat_sel), .addr(f_addr)
  );

  bgf_host_port #(.AW(AW), .DW(DW)) u_host (
    .clk(clk), .rst_n(rst_n), .allow(!render_act),
    .req_valid(host_req_valid), .req_ready(host_req_ready), .req_we(host_req_we),
    .req_addr(host_req_addr), .req_wdata(host_req_wdata), .ad_in(ad_in),
    .busy(host_busy), .ale(h_ale), .rd_n(h_rd_n), .wr_n(h_wr_n), .drive_lo(h_drive),
    .cur_addr(h_addr), .lo_out(h_lo),
    .rsp_valid(host_rsp_valid), .rsp_data(host_rsp_data)
  );

  // bus ownership: a running host access wins over the fetch slots
  always_comb begin
    pa_hi  = '0;
    ad_out = '0;
    ad_oe  = 1'b0;
    ale    = 1'b0;
    rd_n   = 1'b1;
    wr_n   = 1'b1;
    if (host_busy) begin
      pa_hi  = h_addr[AW-1:DW];
      ad_out = h_lo;
      ad_oe  = h_drive;
      ale    = h_ale;
      rd_n   = h_rd_n;
      wr_n   = h_wr_n;
    end else if (fetch_drv && (slot.adr || slot.dat || slot.idle_ale)) begin
      pa_hi  = f_addr[AW-1:DW];
      ad_out = f_addr[DW-1:0];
      ad_oe  = slot.adr || slot.idle_ale;
      ale    = slot.adr || slot.idle_ale;
      rd_n   = !slot.dat;
    end
  end

  assign scroll_hinc    = render_act && s_hinc;
  assign scroll_vinc    = render_act && s_vinc;
  assign scroll_hreload = render_act && s_hrel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fb_valid <= 1'b0;
      fb_kind  <= 2'd0;
      fb_data  <= '0;
      tile_q   <= '0;
    end else begin
      fb_valid <= fetch_drv && slot.dat && !slot.dummy;
      if (fetch_drv && slot.dat && !slot.dummy) begin
        fb_kind <= slot.kind;
        fb_data <= ad_in;
        if (slot.kind == FK_NAME) tile_q <= ad_in;
      end
    end
  end
endmodule

// File: rtl/bgf_sequencer_chk.sv
module bgf_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic fb_valid,
  input logic scroll_hinc,
  input logic scroll_vinc,
  input logic scroll_hreload,
  input logic render_en,
  input logic host_req_valid,
  input logic host_req_ready,
  input logic host_busy
);
  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R12
  ale_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n));

  // R6
  fb_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_valid |-> $past(!rd_n));

  // R8
  vinc_with_hinc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scroll_vinc |-> scroll_hinc);

  // R8
  reload_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scroll_hreload |-> (!scroll_hinc && !scroll_vinc));

  // R10
  host_wait_dot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req_valid && host_req_ready) |=> (rd_n && wr_n && !ale));

  // R10
  host_addr_dot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req_valid && host_req_ready) |-> ##2 ale);

  // R9
  render_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!render_en && !host_busy) |-> (rd_n && !ale));
endmodule

bind bgf_sequencer bgf_sequencer_chk u_chk (.*);

// File: tb/sim_bgf_sequencer.sv
`timescale 1ns/1ps
module sim_bgf_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  dot = '0;
  logic [8:0]  line = '0;
  logic        render_en = 1'b0;
  logic [14:0] scroll_v = '0;
  logic        pat_sel = 1'b1;
  logic        host_req_valid = 1'b0;
  logic        host_req_ready;
  logic        host_req_we = 1'b0;
  logic [13:0] host_req_addr = '0;
  logic [7:0]  host_req_wdata = '0;
  logic        host_rsp_valid;
  logic [7:0]  host_rsp_data;
  logic [5:0]  pa_hi;
  logic [7:0]  ad_out;
  logic        ad_oe;
  logic [7:0]  ad_in;
  logic        ale, rd_n, wr_n;
  logic        fb_valid;
  logic [1:0]  fb_kind;
  logic [7:0]  fb_data;
  logic        scroll_hinc, scroll_vinc, scroll_hreload;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  bgf_sequencer u0 (.*);

  // bench memory: byte is a fixed function of the latched address
  function automatic logic [7:0] memf(input logic [13:0] a);
    return a[7:0] ^ {2'b00, a[13:8]} ^ 8'h5A;
  endfunction

  logic [13:0] lat = '0;
  always @(posedge clk) if (ale) lat <= {pa_hi, ad_out};
  assign ad_in = memf(lat);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  logic [7:0] etile = '0;
  bit         pv = 0;
  logic [1:0] pk = '0;
  logic [7:0] pd = '0;

  task automatic sweep(input int ln, input bit ren, input logic [14:0] vv);
    line = 9'(ln); render_en = ren; scroll_v = vv;
    for (int d = 0; d <= 340; d++) begin
      bit act, mainr, dum, adr, dat, eale;
      int kind;
      logic [13:0] ea;
      string tag;
      @(negedge clk); dot = 9'(d); #1;
      act   = ren && (ln < 240 || ln == 261);
      mainr = (d >= 1 && d <= 256) || (d >= 321 && d <= 336);
      dum   = (d >= 337 && d <= 340);
      adr   = act && (mainr || dum) && (d % 2 == 1);
      dat   = act && (mainr || dum) && (d % 2 == 0);
      kind  = mainr ? ((d - 1) / 2) % 4 : 0;
      case (kind)
        0: ea = {2'b10, vv[11:0]};
        1: ea = {2'b10, vv[11:10], 4'b1111, vv[9:7], vv[4:2]};
        2: ea = {1'b0, pat_sel, etile, 1'b0, vv[14:12]};
        default: ea = {1'b0, pat_sel, etile, 1'b1, vv[14:12]};
      endcase
      eale = adr || (act && d == 0);
      tag = !act ? "R9" : (d == 0 ? "R4" : (dum ? "R5" : ((d > 256 && d < 321) ? "R4" : "R2")));
      chk(tag, ale, eale);
      chk(tag, rd_n, !dat);
      chk("R12", wr_n, 1);
      if (eale) chk("R3", {pa_hi, ad_out}, ea);
      if (eale) chk("R2", ad_oe, 1);
      if (dat) chk("R2", pa_hi, ea[13:8]);
      if (dat) chk("R2", ad_oe, 0);
      chk("R7", scroll_hinc, act && mainr && ((d - 1) % 8 == 7));
      chk("R8", scroll_vinc, act && d == 256);
      chk("R8", scroll_hreload, act && d == 257);
      chk(dum ? "R5" : "R6", fb_valid, pv);
      if (pv) begin
        chk("R6", fb_kind, pk);
        chk("R6", fb_data, pd);
      end
      pv = dat && !dum;
      pk = 2'(kind);
      pd = memf(ea);
      if (dat && !dum && kind == 0) etile = memf(ea);
    end
  endtask

  task automatic host(input bit wr, input logic [13:0] a, input logic [7:0] wd);
    @(negedge clk);
    host_req_valid = 1; host_req_we = wr; host_req_addr = a; host_req_wdata = wd;
    #1 chk("R10", host_req_ready, 1);
    @(negedge clk); host_req_valid = 0; #1;   // wait dot
    chk("R10", ale, 0); chk("R10", rd_n, 1); chk("R10", wr_n, 1);
    @(negedge clk); #1;                       // address dot
    chk("R10", ale, 1); chk("R10", {pa_hi, ad_out}, a); chk("R10", ad_oe, 1);
    @(negedge clk); #1;                       // hold dot
    chk("R10", ale, 0); chk("R10", ad_oe, 1); chk("R10", {pa_hi, ad_out}, a);
    @(negedge clk); #1;                       // transfer dot
    chk("R12", ale, 0);
    if (wr) begin
      chk("R11", wr_n, 0); chk("R11", rd_n, 1);
      chk("R11", ad_out, wd); chk("R11", ad_oe, 1);
    end else begin
      chk("R11", rd_n, 0); chk("R11", wr_n, 1);
      chk("R11", ad_oe, 0); chk("R11", pa_hi, a[13:8]);
    end
    @(negedge clk); #1;                       // response
    chk("R11", host_rsp_valid, !wr);
    if (!wr) chk("R11", host_rsp_data, memf(a));
    chk("R10", host_req_ready, 1);
  endtask

  initial begin
    #(5.0 * 150000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", ale, 0); chk("R1", rd_n, 1); chk("R1", wr_n, 1);
    @(negedge clk); rst_n = 1; #1;
    chk("R1", fb_valid, 0); chk("R1", host_rsp_valid, 0);
    chk("R1", host_req_ready, 1); chk("R1", ale, 0); chk("R1", rd_n, 1);

    sweep(5,   1, 15'h5A6B);
    sweep(5,   1, 15'h2C39);
    sweep(261, 1, 15'h7FFF);
    sweep(245, 1, 15'h1234);   // vblank line, rendering on
    sweep(5,   0, 15'h5A6B);   // rendering off

    line = 9'd245; render_en = 1;
    host(0, 14'h3F07, 8'h00);
    host(1, 14'h2155, 8'hC3);
    render_en = 0; line = 9'd10;
    host(0, 14'h0A81, 8'h00);

    // render-active line holds the host off
    line = 9'd5; render_en = 1;
    @(negedge clk); host_req_valid = 1; host_req_we = 0; host_req_addr = 14'h1111;
    for (int i = 0; i < 3; i++) begin
      #1 chk("R10", host_req_ready, 0);
      chk("R10", host_rsp_valid, 0);
      @(negedge clk);
    end
    host_req_valid = 0;

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule